// File: doc/BRIEF.md
# Port Control and Status Handshake Controller

This block is the device-side register set and lifecycle state machine of a queue-based network port, as a host sees it across a 32-bit register interface. The host issues a command by writing the control register with its ownership bit set. One cycle later the device takes the command, clears the ownership bit, and either accepts it or rejects it. An accepted command raises a one-cycle strobe carrying the decoded command code and queue select. A rejected command writes a reason code into the error register.

The device reports its lifecycle state and its events in the status register. Whenever it posts news there (a state change, a rejection, or activity on the response queue), it sets the status ownership bit. That bit drives the interrupt output until the host writes it back to zero. The queue processing behind the strobe is handled elsewhere and is not part of this block.

Top module: `netport_handshake`

## Requirements
- R1: After reset, the status register reads 0x0001_0000 (state field bits 18:16 = 1, undefined). The control and error registers read 0, the interrupt is low and the strobe is low.
- R2: A control write with bit 7 set is taken on the next clock edge. That edge clears bit 7 and keeps the other control bits, which read back unchanged.
- R3: A control register write that arrives while control bit 7 is still set is ignored. The stored word and the command taken are those of the earlier write.
- R4: Command code 1 (control bits 2:0) in the undefined state moves the state field to 2 (initialized) and pulses the strobe. The page address output then holds control bits 31:9 with bits 8:0 zero.
- R5: Command code 2 in the initialized state moves the state field to 4 (enabled) and pulses the strobe.
- R6: Codes 6 and 7 in the enabled state pulse the strobe with that code and with the queue select taken from control bits 9:8 (0 message, 1 datagram, 2 receive, 3 internal). The state does not change.
- R7: A rejected command leaves the state unchanged, gives no strobe, and sets error register bits 2:0. The reason codes are 1 for code 1 outside the undefined state, 2 for code 2 outside the initialized state, 3 for code 6 or 7 before the enabled state, and 4 for any other code.
- R8: A state change or a rejection sets status bit 31. An accepted queue command (code 6 or 7) does not set it.
- R9: A response event pulse sets status bits 7 and 31. On a host write to the status register, writing 0 to either bit clears it and writing 1 keeps it. A device set in the same cycle as a host clear wins.
- R10: The interrupt output is high exactly while status bit 31 is set.
- R11: Any write to the error register (0x20C) clears it. The data register (0x210) reads back what was last written. Reads from any unmapped offset return 0. The control register is at 0x204 and the status register at 0x208.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| rsp_evt | input | 1 | Response queue gained entries |
| cmd_take | output | 1 | One-cycle strobe: command accepted |
| cmd_code | output | 3 | Code of the accepted command |
| cmd_queue | output | 2 | Queue select of the accepted command |
| cmd_pqb | output | DW | Page-aligned queue block address from the last accepted initialize |
| irq | output | 1 | Interrupt: status owned by host |

## Verification
A wrong lifecycle state shows up on the very next command. A legal command is then rejected, or an illegal one is accepted, and the result is visible one cycle after the take as a missing or extra strobe, a wrong error code, or a wrong status state field. A stuck ownership bit shows as a control readback that never clears. It also shows as a second write being taken as a new command, or as an interrupt that does not follow the host's acknowledge on the cycle after the write. Ordering between a device set and a host clear of the same status bit is checked with the two arriving in one cycle.

// File: rtl/netport_pkg.sv
package netport_pkg;
    // lifecycle state encoding (status field)
    localparam logic [2:0] ST_UNDEF = 3'd1;
    localparam logic [2:0] ST_INIT  = 3'd2;
    localparam logic [2:0] ST_ENAB  = 3'd4;
    localparam logic [2:0] ST_STOP  = 3'd6;

    // command codes (control bits 2:0)
    localparam logic [2:0] OP_INIT  = 3'd1;
    localparam logic [2:0] OP_ENAB  = 3'd2;
    localparam logic [2:0] OP_CMDQ  = 3'd6;
    localparam logic [2:0] OP_FREEQ = 3'd7;

    // rejection reasons
    localparam logic [2:0] ERR_NONE   = 3'd0;
    localparam logic [2:0] ERR_INIT   = 3'd1;
    localparam logic [2:0] ERR_ENAB   = 3'd2;
    localparam logic [2:0] ERR_EARLY  = 3'd3;
    localparam logic [2:0] ERR_BADOP  = 3'd4;

    // bit positions
    localparam int CTRL_OWN  = 7;
    localparam int QSEL_LSB  = 8;
    localparam int STAT_OWN  = 31;
    localparam int STAT_RSQ  = 7;
    localparam int STATE_LSB = 16;

    // register offsets
    localparam int OFS_CTRL = 'h204;
    localparam int OFS_STAT = 'h208;
    localparam int OFS_ERR  = 'h20C;
    localparam int OFS_DATA = 'h210;
endpackage

// File: rtl/netport_decode.sv
module netport_decode
    import netport_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] code,
    input  logic [2:0] state,
    output logic       accept,
    output logic       reject,
    output logic [2:0] reason,
    output logic [2:0] next_state,
    output logic       post
);
    always_comb begin
        accept     = 1'b0;
        reject     = 1'b0;
        reason     = ERR_NONE;
        next_state = state;
        post       = 1'b0;
        if (valid) begin
            case (code)
                OP_INIT: begin
                    if (state == ST_UNDEF) begin
                        accept     = 1'b1;
                        next_state = ST_INIT;
                        post       = 1'b1;
                    end else begin
                        reason = ERR_INIT;
                    end
                end
                OP_ENAB: begin
                    if (state == ST_INIT) begin
                        accept     = 1'b1;
                        next_state = ST_ENAB;
                        post       = 1'b1;
                    end else begin
                        reason = ERR_ENAB;
                    end
                end
                OP_CMDQ, OP_FREEQ: begin
                    if (state == ST_ENAB) accept = 1'b1;
                    else                  reason = ERR_EARLY;
                end
                default: reason = ERR_BADOP;
            endcase
            if (!accept) begin
                reject = 1'b1;
                post   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/netport_status.sv
module netport_status (
    input  logic clk,
    input  logic rst_n,
    input  logic host_wr,
    input  logic keep_own,
    input  logic keep_rsq,
    input  logic post,
    input  logic rsp_evt,
    output logic own,
    output logic rsq
);
    typedef struct packed {
        logic own;
        logic rsq;
    } stat_t;

    stat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (host_wr) begin
            s_d.own = s_q.own & keep_own;
            s_d.rsq = s_q.rsq & keep_rsq;
        end
        // device sets take priority over a host clear in the same cycle
        if (post || rsp_evt) s_d.own = 1'b1;
        if (rsp_evt)         s_d.rsq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign own = s_q.own;
    assign rsq = s_q.rsq;

    // R9: an event is always visible on the next cycle
    p_evt_post_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_evt |=> (own && rsq));

    // R9: without a host write the status flags never fall
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && own) |=> own);
endmodule

// File: rtl/netport_handshake.sv
module netport_handshake
    import netport_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 12,
    parameter int PAGE_BITS = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          rsp_evt,
    output logic          cmd_take,
    output logic [2:0]    cmd_code,
    output logic [1:0]    cmd_queue,
    output logic [DW-1:0] cmd_pqb,
    output logic          irq
);
    localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
    localparam logic [AW-1:0] A_ERR  = AW'(OFS_ERR);
    localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
    localparam int            HI_W   = DW - PAGE_BITS;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [2:0]    err;
        logic [DW-1:0] data;
        logic [2:0]    state;
        logic          take;
        logic [2:0]    code;
        logic [1:0]    queue;
        logic [DW-1:0] pqb;
    } regs_t;

    regs_t r_d, r_q;

    logic       busy;
    logic       acc, rej, post;
    logic [2:0] reason, nxt_state;
    logic       st_own, st_rsq;
    logic       wr_ctrl, wr_stat, wr_err, wr_data;

    assign busy    = r_q.ctrl[CTRL_OWN];
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL) && !busy;
    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign wr_err  = reg_wr && (reg_addr == A_ERR);
    assign wr_data = reg_wr && (reg_addr == A_DATA);

    netport_decode u_dec (
        .valid      (busy),
        .code       (r_q.ctrl[2:0]),
        .state      (r_q.state),
        .accept     (acc),
        .reject     (rej),
        .reason     (reason),
        .next_state (nxt_state),
        .post       (post)
    );

    netport_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (wr_stat),
        .keep_own (reg_wdata[STAT_OWN]),
        .keep_rsq (reg_wdata[STAT_RSQ]),
        .post     (post),
        .rsp_evt  (rsp_evt),
        .own      (st_own),
        .rsq      (st_rsq)
    );

    always_comb begin
        r_d      = r_q;
        r_d.take = 1'b0;
        if (wr_err)  r_d.err  = ERR_NONE;
        if (wr_data) r_d.data = reg_wdata;
        if (busy) begin
            r_d.ctrl[CTRL_OWN] = 1'b0;
            r_d.state          = nxt_state;
            if (acc) begin
                r_d.take  = 1'b1;
                r_d.code  = r_q.ctrl[2:0];
                r_d.queue = r_q.ctrl[QSEL_LSB+1:QSEL_LSB];
                if (r_q.ctrl[2:0] == OP_INIT)
                    r_d.pqb = {r_q.ctrl[DW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
            end
            if (rej) r_d.err = reason;
        end else if (wr_ctrl) begin
            r_d.ctrl = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_UNDEF;
        end else begin
            r_q <= r_d;
        end
    end

    logic [DW-1:0] stat_word;
    always_comb begin
        stat_word                            = '0;
        stat_word[STAT_OWN]                  = st_own;
        stat_word[STATE_LSB+2:STATE_LSB]     = r_q.state;
        stat_word[STAT_RSQ]                  = st_rsq;
        case (reg_addr)
            A_CTRL:  reg_rdata = r_q.ctrl;
            A_STAT:  reg_rdata = stat_word;
            A_ERR:   reg_rdata = {{(DW-3){1'b0}}, r_q.err};
            A_DATA:  reg_rdata = r_q.data;
            default: reg_rdata = '0;
        endcase
    end

    assign cmd_take  = r_q.take;
    assign cmd_code  = r_q.code;
    assign cmd_queue = r_q.queue;
    assign cmd_pqb   = r_q.pqb;
    assign irq       = st_own;

    // R2: a pending command is always taken on the next edge
    p_own_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !r_q.ctrl[CTRL_OWN]);

    // R3: a control write during a pending command leaves the word untouched
    p_ignored_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == A_CTRL) |=>
            (r_q.ctrl[DW-1:CTRL_OWN+1] == $past(r_q.ctrl[DW-1:CTRL_OWN+1])));

    // R6: a strobe only follows a pending command
    p_take_after_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_take |-> $past(busy));

    // R8: every state change is posted to the host
    p_state_posted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != $past(r_q.state)) |-> irq);

    // R1: only the reachable lifecycle encodings occur
    p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_UNDEF) || (r_q.state == ST_INIT) || (r_q.state == ST_ENAB));

    // R7: a command is never both accepted and rejected
    always_comb begin
        p_acc_rej_r7: assert (!(acc && rej));
    end
endmodule

// File: tb/netport_handshake_bench.sv
module netport_handshake_bench;
    localparam logic [11:0] A_CTRL = 12'h204;
    localparam logic [11:0] A_STAT = 12'h208;
    localparam logic [11:0] A_ERR  = 12'h20C;
    localparam logic [11:0] A_DATA = 12'h210;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rsp_evt = 1'b0;
    logic        cmd_take;
    logic [2:0]  cmd_code;
    logic [1:0]  cmd_queue;
    logic [31:0] cmd_pqb;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    netport_handshake u_netport_handshake (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rsp_evt(rsp_evt),
        .cmd_take(cmd_take), .cmd_code(cmd_code), .cmd_queue(cmd_queue),
        .cmd_pqb(cmd_pqb), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] wd;
        logic        take;
        logic [2:0]  code;
        logic [1:0]  q;
        logic [2:0]  err;
        logic [2:0]  st;
        logic        post;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0082, 1'b0, 3'd0, 2'd0, 3'd2, 3'd1, 1'b1},
        '{32'h0000_0087, 1'b0, 3'd0, 2'd0, 3'd3, 3'd1, 1'b1},
        '{32'h0000_0085, 1'b0, 3'd0, 2'd0, 3'd4, 3'd1, 1'b1},
        '{32'h0001_2081, 1'b1, 3'd1, 2'd0, 3'd0, 3'd2, 1'b1},
        '{32'h0000_0081, 1'b0, 3'd0, 2'd0, 3'd1, 3'd2, 1'b1},
        '{32'h0000_0086, 1'b0, 3'd0, 2'd0, 3'd3, 3'd2, 1'b1},
        '{32'h0000_0082, 1'b1, 3'd2, 2'd0, 3'd0, 3'd4, 1'b1},
        '{32'h0000_0187, 1'b1, 3'd7, 2'd1, 3'd0, 3'd4, 1'b0},
        '{32'h0000_0286, 1'b1, 3'd6, 2'd2, 3'd0, 3'd4, 1'b0},
        '{32'h0000_0387, 1'b1, 3'd7, 2'd3, 3'd0, 3'd4, 1'b0},
        '{32'h0000_0082, 1'b0, 3'd0, 2'd0, 3'd2, 3'd4, 1'b1},
        '{32'h0000_0080, 1'b0, 3'd0, 2'd0, 3'd4, 3'd4, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x00000001 expected 0x00000000");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_STAT, v); chk("R1 status", v, 32'h0001_0000);
        rd(A_CTRL, v); chk("R1 control", v, 32'h0);
        rd(A_ERR, v);  chk("R1 error", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 strobe", 32'(cmd_take), 32'h0);

        // table walk: R4 R5 R6 R7 R8 R10, R2 control readback
        for (int i = 0; i < NV; i++) begin
            wr(A_ERR, 32'h0);
            wr(A_STAT, 32'h0);
            wr(A_CTRL, VECS[i].wd);
            @(negedge clk);
            chk("R6 R7 strobe", 32'(cmd_take), 32'(VECS[i].take));
            if (VECS[i].take) begin
                chk("R6 code", 32'(cmd_code), 32'(VECS[i].code));
                chk("R6 queue", 32'(cmd_queue), 32'(VECS[i].q));
            end
            if (VECS[i].take && VECS[i].code == 3'd1)
                chk("R4 page address", cmd_pqb, VECS[i].wd & 32'hFFFF_FE00);
            chk("R10 irq", 32'(irq), 32'(VECS[i].post));
            rd(A_STAT, v);
            chk("R4 R5 R8 status", v, {VECS[i].post, 12'h0, VECS[i].st, 16'h0});
            rd(A_ERR, v);
            chk("R7 error", v, 32'(VECS[i].err));
            rd(A_CTRL, v);
            chk("R2 control readback", v, VECS[i].wd & ~32'h80);
        end

        // R3: second write while own is set is ignored
        wr(A_ERR, 32'h0);
        wr(A_STAT, 32'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'h0000_0186;
        @(negedge clk);
        reg_wdata = 32'h0003_4081;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R3 strobe", 32'(cmd_take), 32'h1);
        chk("R3 code", 32'(cmd_code), 32'h6);
        chk("R3 queue", 32'(cmd_queue), 32'h1);
        @(negedge clk);
        chk("R3 no second strobe", 32'(cmd_take), 32'h0);
        rd(A_CTRL, v); chk("R3 control kept", v, 32'h0000_0106);
        rd(A_ERR, v);  chk("R3 no rejection", v, 32'h0);
        chk("R3 page address kept", cmd_pqb, 32'h0001_2000);

        // R9 R10: response event and host acknowledge
        @(negedge clk); rsp_evt = 1'b1;
        @(negedge clk); rsp_evt = 1'b0;
        rd(A_STAT, v); chk("R9 event posted", v, 32'h8004_0080);
        chk("R10 irq on event", 32'(irq), 32'h1);
        wr(A_STAT, 32'h8000_0080);
        rd(A_STAT, v); chk("R9 write ones keeps", v, 32'h8004_0080);
        wr(A_STAT, 32'h0000_0080);
        rd(A_STAT, v); chk("R9 own cleared", v, 32'h0004_0080);
        chk("R10 irq low", 32'(irq), 32'h0);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R9 rsq cleared", v, 32'h0004_0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0; rsp_evt = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; rsp_evt = 1'b0;
        rd(A_STAT, v); chk("R9 set beats clear", v, 32'h8004_0080);

        // R11: data, error clear, unmapped
        wr(A_DATA, 32'hA5A5_5A5A);
        rd(A_DATA, v); chk("R11 data readback", v, 32'hA5A5_5A5A);
        wr(A_CTRL, 32'h0000_0083);
        @(negedge clk);
        rd(A_ERR, v); chk("R11 error set", v, 32'h4);
        wr(A_ERR, 32'hFFFF_FFFF);
        rd(A_ERR, v); chk("R11 error cleared", v, 32'h0);
        rd(12'h300, v); chk("R11 unmapped", v, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule